// File: doc/BRIEF.md
# KV Codec Control and Status Register Block

This block is the register front end of a streaming KV-cache compression engine. A host reaches it over an AXI-Lite-style slave port. It keeps the engine's control bits: an enable and a self-clearing soft reset. It also keeps the target addresses for compress-on-write and decompress-on-read, a key/value selector, and an interrupt mask with a write-one-to-clear pending register. A set of read-only words reports how the engine was built: head dimension, group size, storage depth, codec tier, outlier channel count and the two compression ratios.

The engine reports back through three single-cycle event strobes (write done, read done, storage full) and a busy level. The block counts completed writes as storage occupancy, latches the events as interrupt causes, and drives one interrupt line. Writing the read-address register hands the engine a one-cycle decompress launch pulse together with the new address.

Top module: `kv_codec_regs`

## Requirements
- R1: After reset every writable register, the occupancy count, the pending interrupts, the launch pulse, the soft-reset output, the interrupt line and both bus response valids are 0.
- R2: A write is taken in the cycle where address-valid and data-valid are both high and no write response is outstanding. A read is taken when no read data is outstanding. Each transfer returns one response with code 0 (OKAY). Read data and its valid are held until read-ready.
- R3: The control word at offset 0x00 holds enable in bit 1, which drives the enable output. Writing bit 0 as 1 raises the soft-reset output for exactly one cycle. The bit then reads back as 0.
- R4: During the soft-reset cycle the occupancy, the write address, the read address and the pending interrupts clear, and events in that cycle are dropped. Enable, the key/value select and the interrupt mask keep their values.
- R5: A write to offset 0x2C stores the read address. The next cycle carries a one-cycle launch pulse with that address on the read-address output. A write to any other offset gives no pulse.
- R6: Offset 0x28 holds the write address and 0x2C the read address, each clog2(DEPTH) bits wide, with higher data bits dropped. Offset 0x30 bit 0 selects the value path (1) or the key path (0). All three read back and appear on outputs.
- R7: Offset 0x24 reads the occupancy. Occupancy rises by one on each write-done event and saturates at DEPTH. The status word at 0x04 reads bit 0 = idle (engine not busy) and bit 1 = full (occupancy equals DEPTH).
- R8: The pending word at 0x38 holds bit 0 write-done, bit 1 read-done and bit 2 full. Each bit is set by its event and cleared by writing 1 to it. An event in the same cycle as a clear leaves the bit set.
- R9: The mask word at 0x34 holds three bits. The interrupt output is high while any pending bit is set and its mask bit is set.
- R10: The read-only words return: 0x08 head dimension, 0x0C tier (0 INT8 both paths, 1 INT4, 2 INT4 with outliers), 0x10 group size, 0x14 storage depth, 0x18 and 0x1C the key and value compression ratios in 8.8 fixed point, 0x20 version 0x00020000, 0x3C outlier channel count, 0x40 scale-bank depth (head dimension), 0x44 residual depth (group size).
- R11: Reading an unmapped offset returns 0. Writing a read-only offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sAwValid | input | 1 | Write address valid |
| sAwReady | output | 1 | Write address ready |
| sAwAddr | input | 8 | Write byte address |
| sWValid | input | 1 | Write data valid |
| sWReady | output | 1 | Write data ready |
| sWData | input | 32 | Write data |
| sBValid | output | 1 | Write response valid |
| sBReady | input | 1 | Write response ready |
| sBResp | output | 2 | Write response code, always 0 |
| sArValid | input | 1 | Read address valid |
| sArReady | output | 1 | Read address ready |
| sArAddr | input | 8 | Read byte address |
| sRValid | output | 1 | Read data valid |
| sRReady | input | 1 | Read data ready |
| sRData | output | 32 | Read data |
| sRResp | output | 2 | Read response code, always 0 |
| evWriteDone | input | 1 | Engine finished a compress write |
| evReadDone | input | 1 | Engine finished a decompress read |
| evFull | input | 1 | Engine reports storage full |
| engineBusy | input | 1 | Engine is working |
| enableOut | output | 1 | Engine enable |
| softResetOut | output | 1 | One-cycle soft reset to the engine |
| writeAddrOut | output | clog2(DEPTH) | Compress target address |
| readAddrOut | output | clog2(DEPTH) | Decompress target address |
| kvSelectOut | output | 1 | 0 key path, 1 value path |
| launchOut | output | 1 | Decompress launch pulse |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH 4, so the occupancy saturation and the full flag are reached after a handful of write-done events. The address fields become two bits wide, so truncation of a wider write is visible. The head dimension, group size, tier, outlier count and both ratios are set to values that differ from the defaults and from each other, so a swapped or hard-wired info word reads wrong.

// File: rtl/kvcr_pkg.sv
`timescale 1ns/1ps
package kvcr_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam int IDX_W  = REG_AW - 2;
  localparam int IRQ_W  = 3;
  localparam logic [REG_DW-1:0] VERSION_WORD = 32'h0002_0000;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] IDX_CTRL   = 6'd0;
  localparam logic [IDX_W-1:0] IDX_STATUS = 6'd1;
  localparam logic [IDX_W-1:0] IDX_DIM    = 6'd2;
  localparam logic [IDX_W-1:0] IDX_TIER   = 6'd3;
  localparam logic [IDX_W-1:0] IDX_GROUP  = 6'd4;
  localparam logic [IDX_W-1:0] IDX_DEPTH  = 6'd5;
  localparam logic [IDX_W-1:0] IDX_CRK    = 6'd6;
  localparam logic [IDX_W-1:0] IDX_CRV    = 6'd7;
  localparam logic [IDX_W-1:0] IDX_VER    = 6'd8;
  localparam logic [IDX_W-1:0] IDX_OCC    = 6'd9;
  localparam logic [IDX_W-1:0] IDX_WADDR  = 6'd10;
  localparam logic [IDX_W-1:0] IDX_RADDR  = 6'd11;
  localparam logic [IDX_W-1:0] IDX_KVSEL  = 6'd12;
  localparam logic [IDX_W-1:0] IDX_IMASK  = 6'd13;
  localparam logic [IDX_W-1:0] IDX_ISTAT  = 6'd14;
  localparam logic [IDX_W-1:0] IDX_OUTK   = 6'd15;
  localparam logic [IDX_W-1:0] IDX_SDEPTH = 6'd16;
  localparam logic [IDX_W-1:0] IDX_RDEPTH = 6'd17;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [REG_DW-1:0] wrData;
    logic [IDX_W-1:0]  rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/kvcr_bus.sv
`timescale 1ns/1ps
module kvcr_bus
  import kvcr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sAwValid,
  output logic              sAwReady,
  input  logic [REG_AW-1:0] sAwAddr,
  input  logic              sWValid,
  output logic              sWReady,
  input  logic [REG_DW-1:0] sWData,
  output logic              sBValid,
  input  logic              sBReady,
  input  logic              sArValid,
  output logic              sArReady,
  input  logic [REG_AW-1:0] sArAddr,
  output logic              sRValid,
  input  logic              sRReady,
  output logic [REG_DW-1:0] sRData,
  input  logic [REG_DW-1:0] rdWord,
  output regStrobe_t        stb
);
  logic bValidQ, rValidQ;
  logic [REG_DW-1:0] rDataQ;
  logic wrAccept, rdAccept;
  logic unusedAddrBits;

  assign wrAccept = sAwValid && sWValid && !bValidQ;
  assign rdAccept = sArValid && !rValidQ;
  assign sAwReady = wrAccept;
  assign sWReady  = wrAccept;
  assign sArReady = !rValidQ;
  assign sBValid  = bValidQ;
  assign sRValid  = rValidQ;
  assign sRData   = rDataQ;
  assign unusedAddrBits = ^{sAwAddr[1:0], sArAddr[1:0]};

  assign stb.wrEn   = wrAccept;
  assign stb.wrIdx  = sAwAddr[REG_AW-1:2];
  assign stb.wrData = sWData;
  assign stb.rdIdx  = sArAddr[REG_AW-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bValidQ <= 1'b0;
      rValidQ <= 1'b0;
      rDataQ  <= '0;
    end else begin
      if (wrAccept)     bValidQ <= 1'b1;
      else if (sBReady) bValidQ <= 1'b0;
      if (rdAccept) begin
        rValidQ <= 1'b1;
        rDataQ  <= rdWord;
      end else if (sRReady) begin
        rValidQ <= 1'b0;
      end
    end
  end

  // R2
  bHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sBValid && !sBReady |=> sBValid);
  // R2
  rHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sRValid && !sRReady |=> sRValid && $stable(sRData));
endmodule

// File: rtl/kvcr_file.sv
`timescale 1ns/1ps
module kvcr_file
  import kvcr_pkg::*;
#(
  parameter int HEAD_DIM   = 64,
  parameter int GROUP_SIZE = 128,
  parameter int DEPTH      = 256,
  parameter int TIER       = 2,
  parameter int OUTLIER_K  = 2,
  parameter logic [15:0] CR_K = 16'h03D0,
  parameter logic [15:0] CR_V = 16'h0380,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int WA_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  output logic [REG_DW-1:0] rdWord,
  input  logic              evWriteDone,
  input  logic              evReadDone,
  input  logic              evFull,
  input  logic              engineBusy,
  output logic              enableOut,
  output logic              softResetOut,
  output logic [WA_W-1:0]   writeAddrOut,
  output logic [WA_W-1:0]   readAddrOut,
  output logic              kvSelectOut,
  output logic              launchOut,
  output logic              irqOut
);
  logic              enableQ, softRstQ, kvSelQ, launchQ;
  logic [WA_W-1:0]   waddrQ, raddrQ;
  logic [IRQ_W-1:0]  maskQ, statQ, evVec, clrVec;
  logic [OCC_W-1:0]  occQ;
  logic              fullNow;
  logic              unusedData;

  function automatic logic wrHit(input logic [IDX_W-1:0] idx);
    return stb.wrEn && (stb.wrIdx == idx);
  endfunction

  assign evVec   = {evFull, evReadDone, evWriteDone};
  assign clrVec  = wrHit(IDX_ISTAT) ? stb.wrData[IRQ_W-1:0] : '0;
  assign fullNow = (occQ == OCC_W'(DEPTH));
  assign unusedData = ^stb.wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      softRstQ <= 1'b0;
      kvSelQ   <= 1'b0;
      launchQ  <= 1'b0;
      waddrQ   <= '0;
      raddrQ   <= '0;
      maskQ    <= '0;
      statQ    <= '0;
      occQ     <= '0;
    end else begin
      softRstQ <= wrHit(IDX_CTRL) && stb.wrData[0];
      launchQ  <= wrHit(IDX_RADDR);
      if (wrHit(IDX_CTRL))  enableQ <= stb.wrData[1];
      if (wrHit(IDX_KVSEL)) kvSelQ  <= stb.wrData[0];
      if (wrHit(IDX_IMASK)) maskQ   <= stb.wrData[IRQ_W-1:0];
      if (softRstQ) begin
        waddrQ <= '0;
        raddrQ <= '0;
        statQ  <= '0;
        occQ   <= '0;
      end else begin
        if (wrHit(IDX_WADDR)) waddrQ <= stb.wrData[WA_W-1:0];
        if (wrHit(IDX_RADDR)) raddrQ <= stb.wrData[WA_W-1:0];
        if (evWriteDone && !fullNow) occQ <= occQ + 1'b1;
        statQ <= (statQ & ~clrVec) | evVec;
      end
    end
  end

  always_comb begin
    rdWord = '0;
    case (stb.rdIdx)
      IDX_CTRL:   rdWord = {30'd0, enableQ, softRstQ};
      IDX_STATUS: rdWord = {30'd0, fullNow, !engineBusy};
      IDX_DIM:    rdWord = REG_DW'(HEAD_DIM);
      IDX_TIER:   rdWord = REG_DW'(TIER);
      IDX_GROUP:  rdWord = REG_DW'(GROUP_SIZE);
      IDX_DEPTH:  rdWord = REG_DW'(DEPTH);
      IDX_CRK:    rdWord = {16'd0, CR_K};
      IDX_CRV:    rdWord = {16'd0, CR_V};
      IDX_VER:    rdWord = VERSION_WORD;
      IDX_OCC:    rdWord = REG_DW'(occQ);
      IDX_WADDR:  rdWord = REG_DW'(waddrQ);
      IDX_RADDR:  rdWord = REG_DW'(raddrQ);
      IDX_KVSEL:  rdWord = {31'd0, kvSelQ};
      IDX_IMASK:  rdWord = REG_DW'(maskQ);
      IDX_ISTAT:  rdWord = REG_DW'(statQ);
      IDX_OUTK:   rdWord = REG_DW'(OUTLIER_K);
      IDX_SDEPTH: rdWord = REG_DW'(HEAD_DIM);
      IDX_RDEPTH: rdWord = REG_DW'(GROUP_SIZE);
      default:    rdWord = '0;
    endcase
  end

  assign enableOut    = enableQ;
  assign softResetOut = softRstQ;
  assign writeAddrOut = waddrQ;
  assign readAddrOut  = raddrQ;
  assign kvSelectOut  = kvSelQ;
  assign launchOut    = launchQ;
  assign irqOut       = |(statQ & maskQ);

  // R3
  softSelfClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstQ |=> !softRstQ);
  // R4
  softClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstQ |=> (occQ == '0) && (statQ == '0) && (waddrQ == '0));
  // R5
  launchPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    launchQ |=> !launchQ);
  // R7
  occBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occQ <= OCC_W'(DEPTH));
  // R8
  doneSetWins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evWriteDone && !softRstQ |=> statQ[0]);
  // R8
  pendSource_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ[1]) |-> $past(evReadDone));
endmodule

// File: rtl/kv_codec_regs.sv
`timescale 1ns/1ps
module kv_codec_regs
  import kvcr_pkg::*;
#(
  parameter int HEAD_DIM   = 64,
  parameter int GROUP_SIZE = 128,
  parameter int DEPTH      = 256,
  parameter int TIER       = 2,
  parameter int OUTLIER_K  = 2,
  parameter logic [15:0] CR_K = 16'h03D0,
  parameter logic [15:0] CR_V = 16'h0380,
  localparam int WA_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sAwValid,
  output logic              sAwReady,
  input  logic [REG_AW-1:0] sAwAddr,
  input  logic              sWValid,
  output logic              sWReady,
  input  logic [REG_DW-1:0] sWData,
  output logic              sBValid,
  input  logic              sBReady,
  output logic [1:0]        sBResp,
  input  logic              sArValid,
  output logic              sArReady,
  input  logic [REG_AW-1:0] sArAddr,
  output logic              sRValid,
  input  logic              sRReady,
  output logic [REG_DW-1:0] sRData,
  output logic [1:0]        sRResp,
  input  logic              evWriteDone,
  input  logic              evReadDone,
  input  logic              evFull,
  input  logic              engineBusy,
  output logic              enableOut,
  output logic              softResetOut,
  output logic [WA_W-1:0]   writeAddrOut,
  output logic [WA_W-1:0]   readAddrOut,
  output logic              kvSelectOut,
  output logic              launchOut,
  output logic              irqOut
);
  regStrobe_t        stb;
  logic [REG_DW-1:0] rdWord;

  assign sBResp = 2'b00;
  assign sRResp = 2'b00;

  kvcr_bus bus_i (
    .clk(clk), .rstN(rstN),
    .sAwValid(sAwValid), .sAwReady(sAwReady), .sAwAddr(sAwAddr),
    .sWValid(sWValid), .sWReady(sWReady), .sWData(sWData),
    .sBValid(sBValid), .sBReady(sBReady),
    .sArValid(sArValid), .sArReady(sArReady), .sArAddr(sArAddr),
    .sRValid(sRValid), .sRReady(sRReady), .sRData(sRData),
    .rdWord(rdWord), .stb(stb)
  );

  kvcr_file #(
    .HEAD_DIM(HEAD_DIM), .GROUP_SIZE(GROUP_SIZE), .DEPTH(DEPTH),
    .TIER(TIER), .OUTLIER_K(OUTLIER_K), .CR_K(CR_K), .CR_V(CR_V)
  ) file_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdWord(rdWord),
    .evWriteDone(evWriteDone), .evReadDone(evReadDone), .evFull(evFull),
    .engineBusy(engineBusy),
    .enableOut(enableOut), .softResetOut(softResetOut),
    .writeAddrOut(writeAddrOut), .readAddrOut(readAddrOut),
    .kvSelectOut(kvSelectOut), .launchOut(launchOut), .irqOut(irqOut)
  );
endmodule

// File: tb/kv_codec_regs_tb_top.sv
`timescale 1ns/1ps
module kv_codec_regs_tb_top;
  localparam int HEAD_DIM = 32, GROUP_SIZE = 16, DEPTH = 4, TIER = 1, OUTLIER_K = 3;
  localparam logic [15:0] CR_K = 16'h0412, CR_V = 16'h0399;
  localparam int WA_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic sAwValid = 0, sWValid = 0, sBReady = 1, sArValid = 0, sRReady = 1;
  logic [7:0] sAwAddr = 0, sArAddr = 0;
  logic [31:0] sWData = 0;
  logic sAwReady, sWReady, sBValid, sArReady, sRValid;
  logic [1:0] sBResp, sRResp;
  logic [31:0] sRData;
  logic evWriteDone = 0, evReadDone = 0, evFull = 0, engineBusy = 0;
  logic enableOut, softResetOut, kvSelectOut, launchOut, irqOut;
  logic [WA_W-1:0] writeAddrOut, readAddrOut;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  kv_codec_regs #(.HEAD_DIM(HEAD_DIM), .GROUP_SIZE(GROUP_SIZE), .DEPTH(DEPTH),
    .TIER(TIER), .OUTLIER_K(OUTLIER_K), .CR_K(CR_K), .CR_V(CR_V)) dut_i (
    .clk(clk), .rstN(rstN),
    .sAwValid(sAwValid), .sAwReady(sAwReady), .sAwAddr(sAwAddr),
    .sWValid(sWValid), .sWReady(sWReady), .sWData(sWData),
    .sBValid(sBValid), .sBReady(sBReady), .sBResp(sBResp),
    .sArValid(sArValid), .sArReady(sArReady), .sArAddr(sArAddr),
    .sRValid(sRValid), .sRReady(sRReady), .sRData(sRData), .sRResp(sRResp),
    .evWriteDone(evWriteDone), .evReadDone(evReadDone), .evFull(evFull),
    .engineBusy(engineBusy),
    .enableOut(enableOut), .softResetOut(softResetOut),
    .writeAddrOut(writeAddrOut), .readAddrOut(readAddrOut),
    .kvSelectOut(kvSelectOut), .launchOut(launchOut), .irqOut(irqOut));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    sAwValid = 1; sWValid = 1; sAwAddr = addr; sWData = data;
    while (!sAwReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    sAwValid = 0; sWValid = 0;
    chk("R2 write response", {29'd0, sBValid, sBResp}, 32'h4);
  endtask

  task automatic regRead(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    sArValid = 1; sArAddr = addr;
    while (!sArReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    sArValid = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    evWriteDone = (which == 0); evReadDone = (which == 1); evFull = (which == 2);
    @(negedge clk);
    evWriteDone = 0; evReadDone = 0; evFull = 0;
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rstN && sRValid && sRReady) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read response: actual=0x%08h expected=none", sRData);
      end else begin
        chk(tagQ.pop_front(), sRData, expQ.pop_front());
        chk("R2 read resp code", {30'd0, sRResp}, 32'd0);
      end
    end
  end

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 outputs", {25'd0, irqOut, launchOut, enableOut, softResetOut, kvSelectOut, sBValid, sRValid}, 32'd0);
    chk("R1 addrs", {28'd0, writeAddrOut, readAddrOut}, 32'd0);
    regRead(8'h00, 32'd0, "R1 ctrl");
    regRead(8'h24, 32'd0, "R1 occupancy");
    regRead(8'h34, 32'd0, "R1 mask");
    regRead(8'h38, 32'd0, "R1 pending");
    // R10 info words
    regRead(8'h08, HEAD_DIM, "R10 dim");
    regRead(8'h0C, TIER, "R10 tier");
    regRead(8'h10, GROUP_SIZE, "R10 group");
    regRead(8'h14, DEPTH, "R10 depth");
    regRead(8'h18, {16'd0, CR_K}, "R10 crk");
    regRead(8'h1C, {16'd0, CR_V}, "R10 crv");
    regRead(8'h20, 32'h0002_0000, "R10 version");
    regRead(8'h3C, OUTLIER_K, "R10 outliers");
    regRead(8'h40, HEAD_DIM, "R10 scale depth");
    regRead(8'h44, GROUP_SIZE, "R10 resid depth");
    // R6 addresses and select
    regWrite(8'h28, 32'h0000_0007);
    chk("R5 no launch on write addr", {31'd0, launchOut}, 32'd0);
    chk("R6 write addr out", {30'd0, writeAddrOut}, 32'd3);
    regRead(8'h28, 32'd3, "R6 write addr truncated");
    regWrite(8'h30, 32'd1);
    chk("R6 kv select out", {31'd0, kvSelectOut}, 32'd1);
    regRead(8'h30, 32'd1, "R6 kv select");
    // R3 enable
    regWrite(8'h00, 32'd2);
    chk("R3 enable out", {31'd0, enableOut}, 32'd1);
    regRead(8'h00, 32'd2, "R3 ctrl readback");
    // R5 launch
    regWrite(8'h2C, 32'd2);
    chk("R5 launch pulse", {29'd0, launchOut, readAddrOut}, 32'h6);
    @(negedge clk);
    chk("R5 launch ends", {31'd0, launchOut}, 32'd0);
    regRead(8'h2C, 32'd2, "R6 read addr");
    // R7 occupancy and status
    engineBusy = 1;
    regRead(8'h04, 32'd0, "R7 busy status");
    drain();
    engineBusy = 0;
    for (int i = 0; i < 3; i++) pulse(0);
    regRead(8'h24, 32'd3, "R7 occupancy partial");
    regRead(8'h04, 32'd1, "R7 idle not full");
    pulse(0); pulse(0);
    regRead(8'h24, DEPTH, "R7 occupancy saturates");
    regRead(8'h04, 32'd3, "R7 idle full");
    // R8 pending and R9 mask
    regRead(8'h38, 32'd1, "R8 write-done pending");
    chk("R9 masked irq low", {31'd0, irqOut}, 32'd0);
    pulse(1); pulse(2);
    regRead(8'h38, 32'd7, "R8 all pending");
    regWrite(8'h34, 32'd2);
    chk("R9 irq high", {31'd0, irqOut}, 32'd1);
    regWrite(8'h38, 32'd2);
    chk("R9 irq after clear", {31'd0, irqOut}, 32'd0);
    regRead(8'h38, 32'd5, "R8 w1c");
    // R11 read-only and unmapped
    regWrite(8'h08, 32'hFFFF);
    regWrite(8'h24, 32'h1);
    regWrite(8'h04, 32'h0);
    regRead(8'h08, HEAD_DIM, "R11 ro dim kept");
    regRead(8'h24, DEPTH, "R11 ro occupancy kept");
    regRead(8'h50, 32'd0, "R11 unmapped");
    regRead(8'hFC, 32'd0, "R11 unmapped top");
    // R4 soft reset
    regWrite(8'h00, 32'd3);
    chk("R3 soft reset pulse", {31'd0, softResetOut}, 32'd1);
    @(negedge clk);
    chk("R3 soft reset ends", {31'd0, softResetOut}, 32'd0);
    chk("R4 addrs cleared", {28'd0, writeAddrOut, readAddrOut}, 32'd0);
    regRead(8'h24, 32'd0, "R4 occupancy cleared");
    regRead(8'h38, 32'd0, "R4 pending cleared");
    regRead(8'h34, 32'd2, "R4 mask kept");
    regRead(8'h30, 32'd1, "R4 select kept");
    regRead(8'h00, 32'd2, "R4 enable kept");
    // R2 read hold
    drain();
    sRReady = 0;
    regRead(8'h20, 32'h0002_0000, "R2 held read");
    repeat (3) @(negedge clk);
    chk("R2 rvalid held", {31'd0, sRValid}, 32'd1);
    chk("R2 rdata held", sRData, 32'h0002_0000);
    sRReady = 1;
    drain();
    chk("R2 all reads answered", expQ.size(), 32'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule